// File: doc/BRIEF.md
# Flash Command Sequencer

This block is a synchronous model of the command front end of a NOR-style parallel flash device. Host bus writes arrive as single-cycle strobes carrying an address, a 16-bit data word and a byte/word mode flag. The block decodes one-cycle and multi-cycle command sequences and applies them to a small word array, a small protection register file and a set of per-block lock bits. The supported sequences are single-word program, buffered write, clear of all lock bits and protection-register program. A programmable busy timer stands in for the internal program time.

Buffered writes and lock clearing take effect only when an explicit confirm code arrives. Any other value in the confirm slot abandons the sequence and flags an error. While the timer runs, reads give only the ready bit; every other bit is masked. Stored bits can only go from 1 to 0: a program ANDs the new data into the old word. The array and protection words reset to all ones.

Top module: `fcmd_seq`

## Requirements
- R1: After reset the block is in array-read mode, every array and protection word reads 0xFFFF with rd_oe = 0xFFFF, and the lock bits equal LOCK_INIT (default: only block 1 locked).
- R2: A command byte of 0x40 or 0x10 starts a single program. The next write ANDs wr_data into the array word at wr_addr.
- R3: While busy, rd_oe is 0x0080 and rd_data bit 7 is 0. When the block is not busy, rd_oe is 0xFFFF.
- R4: Busy lasts exactly BUSY_CYC cycles after the edge that accepts the final write of an operation. After that the block stays in status-read mode with bit 7 = 1. Writes made while busy are ignored.
- R5: Command 0xE8 starts a buffered write. Its second write carries N in data bits 7:0 and the block in wr_addr[5:4]. It is followed by N+1 data writes, each with its word offset in wr_addr[3:0]. A 0xD0 then commits all of them, ANDed into the array. The array is unchanged before the 0xD0.
- R6: N may be at most 0x1F when byte_mode = 1 and at most 0x0F when byte_mode = 0. A larger N abandons the sequence and sets status bit 5.
- R7: A value other than 0xD0 in the confirm slot of a buffered write abandons it with no array change and no busy period, and sets status bit 5.
- R8: A buffered data write whose address lies outside the chosen block abandons the sequence and sets status bit 5.
- R9: 0x60 followed by 0xD0 clears every lock bit at once. 0x60 followed by any other code sets status bit 5 and keeps the lock bits.
- R10: A program or buffered write aimed at a locked block sets status bit 4. It changes nothing and starts no busy period.
- R11: 0xC0 followed by a write ANDs wr_data into protection word wr_addr[1:0]. In array-read mode, a read with rd_addr[6] = 1 returns protection word rd_addr[1:0].
- R12: Command byte 0xFF selects array-read mode. Undefined codes change neither mode nor state. Only data bits 7:0 are decoded in command cycles.
- R13: Reads in status-read mode, or in the middle of a sequence, return {8'h00, status}. The status byte has bit 7 = ready, bit 5 = sequence error and bit 4 = lock error. Accepting a setup code (0x40, 0x10, 0xE8, 0x60, 0xC0) clears both error bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | One-cycle write strobe |
| wr_addr | input | ARR_AW (6) | Write word address |
| wr_data | input | 16 | Write data or command code |
| byte_mode | input | 1 | 1 = byte mode count limits |
| rd_addr | input | ARR_AW+1 (7) | Read address; top bit selects the protection words |
| rd_data | output | 16 | Read data |
| rd_oe | output | 16 | Per-bit valid mask of rd_data |

## Verification
The bound checker watches the following on every cycle:
- the masked read shape while busy and the upper bound on the busy run;
- that writes during busy are ignored;
- the abort on a wrong confirm code or an out-of-range count;
- lock clearing, lock refusal, and that undefined codes leave the mode alone.

The actual stored values can only be shown by the bench's scenarios, which use a reference model:
- the AND-merging of programs;
- buffered commits, including byte-mode counts that revisit the same offset;
- protection-word contents;
- the exact busy length measured at the ports.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;
   typedef enum logic [2:0] {
      CK_NONE, CK_PGM, CK_BUF, CK_CLR, CK_PROT, CK_ARRAY
   } cmd_kind_e;

   typedef enum logic [2:0] {
      S_IDLE, S_PGM_DATA, S_BUF_CNT, S_BUF_DATA, S_BUF_CONF, S_CLR_CONF, S_PROT_DATA
   } seq_state_e;

   typedef enum logic {
      RM_ARRAY, RM_STATUS
   } rd_mode_e;

   localparam logic [7:0] OP_PGM_A   = 8'h40;
   localparam logic [7:0] OP_PGM_B   = 8'h10;
   localparam logic [7:0] OP_BUF     = 8'hE8;
   localparam logic [7:0] OP_CLR     = 8'h60;
   localparam logic [7:0] OP_PROT    = 8'hC0;
   localparam logic [7:0] OP_ARRAY   = 8'hFF;
   localparam logic [7:0] OP_CONFIRM = 8'hD0;

   localparam int ST_READY    = 7;
   localparam int ST_SEQ_ERR  = 5;
   localparam int ST_LOCK_ERR = 4;
endpackage

// File: rtl/fcmd_decode.sv
module fcmd_decode
   import fcmd_pkg::*;
(
   input  logic [7:0] code,
   output cmd_kind_e  kind,
   output logic       confirm
);
   always_comb begin
      unique case (code)
         OP_PGM_A, OP_PGM_B: kind = CK_PGM;
         OP_BUF:             kind = CK_BUF;
         OP_CLR:             kind = CK_CLR;
         OP_PROT:            kind = CK_PROT;
         OP_ARRAY:           kind = CK_ARRAY;
         default:            kind = CK_NONE;
      endcase
   end
   assign confirm = (code == OP_CONFIRM);
endmodule

// File: rtl/fcmd_timer.sv
module fcmd_timer #(
   parameter int BUSY_CYC = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   localparam int CW = $clog2(BUSY_CYC + 1);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)              cnt_q <= '0;
      else if (start)          cnt_q <= CW'(BUSY_CYC);
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end
   assign busy = (cnt_q != '0);
endmodule

// File: rtl/fcmd_store.sv
module fcmd_store #(
   parameter int ARR_AW  = 6,
   parameter int BLK_AW  = 4,
   parameter int PROT_AW = 2,
   parameter int BUF_AW  = 5,
   parameter logic [(1<<(ARR_AW-BLK_AW))-1:0] LOCK_INIT = '0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       pgm_we,
   input  logic [ARR_AW-1:0]          pgm_addr,
   input  logic [15:0]                pgm_data,
   input  logic                       prot_we,
   input  logic                       buf_we,
   input  logic [BUF_AW-1:0]          buf_idx,
   input  logic                       commit,
   input  logic [BUF_AW-1:0]          commit_n,
   input  logic [ARR_AW-BLK_AW-1:0]   commit_blk,
   input  logic                       clr_locks,
   input  logic [ARR_AW:0]            rd_addr,
   output logic [15:0]                rd_word,
   output logic [(1<<(ARR_AW-BLK_AW))-1:0] locks
);
   localparam int WORDS = 1 << ARR_AW;
   localparam int PWORDS = 1 << PROT_AW;
   localparam int DEPTH = 1 << BUF_AW;
   localparam int NBLK_W = ARR_AW - BLK_AW;

   logic [15:0]       arr_q  [WORDS];
   logic [15:0]       prot_q [PWORDS];
   logic [BLK_AW-1:0] boff_q [DEPTH];
   logic [15:0]       bdat_q [DEPTH];
   logic [(1<<NBLK_W)-1:0] lock_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < WORDS; i++) arr_q[i] <= '1;
         for (int i = 0; i < PWORDS; i++) prot_q[i] <= '1;
         lock_q <= LOCK_INIT;
      end else begin
         if (pgm_we) arr_q[pgm_addr] <= arr_q[pgm_addr] & pgm_data;
         if (prot_we) prot_q[pgm_addr[PROT_AW-1:0]] <= prot_q[pgm_addr[PROT_AW-1:0]] & pgm_data;
         if (clr_locks) lock_q <= '0;
         if (commit) begin
            for (int i = 0; i < DEPTH; i++) begin
               if (BUF_AW'(i) <= commit_n)
                  arr_q[{commit_blk, boff_q[i]}] <= arr_q[{commit_blk, boff_q[i]}] & bdat_q[i];
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (buf_we) begin
         boff_q[buf_idx] <= pgm_addr[BLK_AW-1:0];
         bdat_q[buf_idx] <= pgm_data;
      end
   end

   assign rd_word = rd_addr[ARR_AW] ? prot_q[rd_addr[PROT_AW-1:0]] : arr_q[rd_addr[ARR_AW-1:0]];
   assign locks   = lock_q;
endmodule

// File: rtl/fcmd_rdmux.sv
module fcmd_rdmux #(
   parameter bit HIZ_MASKED = 1'b0
) (
   input  logic        busy,
   input  logic        show_status,
   input  logic [7:0]  status,
   input  logic [15:0] word,
   output logic [15:0] rd_data,
   output logic [15:0] rd_oe
);
   logic [15:0] raw;

   always_comb begin
      if (busy) begin
         raw   = {8'h00, 1'b0, 7'h00};
         rd_oe = 16'h0080;
      end else if (show_status) begin
         raw   = {8'h00, status};
         rd_oe = 16'hFFFF;
      end else begin
         raw   = word;
         rd_oe = 16'hFFFF;
      end
   end

   generate
      if (HIZ_MASKED) begin : g_hiz
         for (genvar b = 0; b < 16; b++) begin : g_bit
            assign rd_data[b] = rd_oe[b] ? raw[b] : 1'bz;
         end
      end else begin : g_zero
         assign rd_data = raw;
      end
   endgenerate
endmodule

// File: rtl/fcmd_seq.sv
module fcmd_seq
   import fcmd_pkg::*;
#(
   parameter int ARR_AW     = 6,
   parameter int BLK_AW     = 4,
   parameter int PROT_AW    = 2,
   parameter int BUF_AW     = 5,
   parameter int BUSY_CYC   = 5,
   parameter bit HIZ_MASKED = 1'b0,
   parameter logic [(1<<(ARR_AW-BLK_AW))-1:0] LOCK_INIT = 4'b0010
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic [ARR_AW-1:0] wr_addr,
   input  logic [15:0]       wr_data,
   input  logic              byte_mode,
   input  logic [ARR_AW:0]   rd_addr,
   output logic [15:0]       rd_data,
   output logic [15:0]       rd_oe
);
   localparam int NBLK_W = ARR_AW - BLK_AW;
   localparam int DEPTH  = 1 << BUF_AW;
   localparam logic [7:0] NMAX_BYTE = 8'(DEPTH - 1);
   localparam logic [7:0] NMAX_WORD = 8'(DEPTH / 2 - 1);

   generate
      if (BLK_AW < 1 || BLK_AW >= ARR_AW) begin : g_bad_blk
         $error("BLK_AW must lie in 1..ARR_AW-1");
      end
      if (PROT_AW < 1 || PROT_AW > ARR_AW) begin : g_bad_prot
         $error("PROT_AW must lie in 1..ARR_AW");
      end
      if (BUF_AW < 1 || BUF_AW > 8) begin : g_bad_buf
         $error("BUF_AW must lie in 1..8");
      end
      if (BUSY_CYC < 1) begin : g_bad_busy
         $error("BUSY_CYC must be at least 1");
      end
      if (ARR_AW > 10) begin : g_bad_arr
         $error("ARR_AW limited to 10");
      end
   endgenerate

   seq_state_e state_q, st_d;
   rd_mode_e   mode_q, mode_d;
   logic       seq_err_q, seq_d, lock_err_q, lk_d;
   logic [BUF_AW-1:0] n_q, n_d, idx_q, idx_d;
   logic [NBLK_W-1:0] blk_q, blk_d;

   cmd_kind_e kind;
   logic      confirm, busy;
   logic      pgm_we, prot_we, buf_we, commit, clr_locks, start;
   logic [(1<<NBLK_W)-1:0] lock_vec;
   logic [15:0] word;
   logic [7:0]  status, nmax;
   logic [NBLK_W-1:0] wr_blk;

   assign wr_blk = wr_addr[ARR_AW-1:BLK_AW];
   assign nmax   = byte_mode ? NMAX_BYTE : NMAX_WORD;

   fcmd_decode dec_i (.code(wr_data[7:0]), .kind(kind), .confirm(confirm));

   fcmd_timer #(.BUSY_CYC(BUSY_CYC)) tmr_i (
      .clk(clk), .rst_n(rst_n), .start(start), .busy(busy));

   always_comb begin
      st_d = state_q; mode_d = mode_q; seq_d = seq_err_q; lk_d = lock_err_q;
      n_d = n_q; idx_d = idx_q; blk_d = blk_q;
      pgm_we = 1'b0; prot_we = 1'b0; buf_we = 1'b0;
      commit = 1'b0; clr_locks = 1'b0; start = 1'b0;
      if (wr_stb && !busy) begin
         unique case (state_q)
            S_IDLE: begin
               if (kind == CK_ARRAY) mode_d = RM_ARRAY;
               else if (kind != CK_NONE) begin
                  mode_d = RM_STATUS; seq_d = 1'b0; lk_d = 1'b0;
                  unique case (kind)
                     CK_PGM:  st_d = S_PGM_DATA;
                     CK_BUF:  st_d = S_BUF_CNT;
                     CK_CLR:  st_d = S_CLR_CONF;
                     default: st_d = S_PROT_DATA;
                  endcase
               end
            end
            S_PGM_DATA: begin
               st_d = S_IDLE;
               if (lock_vec[wr_blk]) lk_d = 1'b1;
               else begin pgm_we = 1'b1; start = 1'b1; end
            end
            S_BUF_CNT: begin
               if (wr_data[7:0] > nmax) begin seq_d = 1'b1; st_d = S_IDLE; end
               else if (lock_vec[wr_blk]) begin lk_d = 1'b1; st_d = S_IDLE; end
               else begin
                  n_d = wr_data[BUF_AW-1:0]; blk_d = wr_blk; idx_d = '0; st_d = S_BUF_DATA;
               end
            end
            S_BUF_DATA: begin
               if (wr_blk != blk_q) begin seq_d = 1'b1; st_d = S_IDLE; end
               else begin
                  buf_we = 1'b1;
                  if (idx_q == n_q) st_d = S_BUF_CONF;
                  else idx_d = idx_q + 1'b1;
               end
            end
            S_BUF_CONF: begin
               st_d = S_IDLE;
               if (confirm) begin commit = 1'b1; start = 1'b1; end
               else seq_d = 1'b1;
            end
            S_CLR_CONF: begin
               st_d = S_IDLE;
               if (confirm) begin clr_locks = 1'b1; start = 1'b1; end
               else seq_d = 1'b1;
            end
            S_PROT_DATA: begin
               st_d = S_IDLE; prot_we = 1'b1; start = 1'b1;
            end
            default: st_d = S_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= S_IDLE; mode_q <= RM_ARRAY;
         seq_err_q <= 1'b0; lock_err_q <= 1'b0;
         n_q <= '0; idx_q <= '0; blk_q <= '0;
      end else begin
         state_q <= st_d; mode_q <= mode_d;
         seq_err_q <= seq_d; lock_err_q <= lk_d;
         n_q <= n_d; idx_q <= idx_d; blk_q <= blk_d;
      end
   end

   fcmd_store #(
      .ARR_AW(ARR_AW), .BLK_AW(BLK_AW), .PROT_AW(PROT_AW),
      .BUF_AW(BUF_AW), .LOCK_INIT(LOCK_INIT)
   ) sto_i (
      .clk(clk), .rst_n(rst_n),
      .pgm_we(pgm_we), .pgm_addr(wr_addr), .pgm_data(wr_data),
      .prot_we(prot_we), .buf_we(buf_we), .buf_idx(idx_q),
      .commit(commit), .commit_n(n_q), .commit_blk(blk_q),
      .clr_locks(clr_locks), .rd_addr(rd_addr), .rd_word(word), .locks(lock_vec));

   always_comb begin
      status = 8'h00;
      status[ST_READY]    = !busy;
      status[ST_SEQ_ERR]  = seq_err_q;
      status[ST_LOCK_ERR] = lock_err_q;
   end

   fcmd_rdmux #(.HIZ_MASKED(HIZ_MASKED)) rdm_i (
      .busy(busy), .show_status((mode_q == RM_STATUS) || (state_q != S_IDLE)),
      .status(status), .word(word), .rd_data(rd_data), .rd_oe(rd_oe));
endmodule

// File: rtl/fcmd_seq_chk.sv
module fcmd_seq_chk
   import fcmd_pkg::*;
#(
   parameter int ARR_AW   = 6,
   parameter int BLK_AW   = 4,
   parameter int BUF_AW   = 5,
   parameter int BUSY_CYC = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_stb,
   input logic [ARR_AW-1:0] wr_addr,
   input logic [15:0]       wr_data,
   input logic              byte_mode,
   input logic [15:0]       rd_data,
   input logic [15:0]       rd_oe,
   input seq_state_e        state_q,
   input rd_mode_e          mode_q,
   input logic              busy,
   input logic              seq_err_q,
   input logic              lock_err_q,
   input logic [(1<<(ARR_AW-BLK_AW))-1:0] lock_vec
);
   localparam int DEPTH = 1 << BUF_AW;
   int run_q;
   logic undef_code;
   logic [7:0] lim;

   always_ff @(posedge clk) begin
      if (!rst_n) run_q <= 0;
      else if (busy) run_q <= run_q + 1;
      else run_q <= 0;
   end

   assign undef_code = !(wr_data[7:0] inside {OP_PGM_A, OP_PGM_B, OP_BUF, OP_CLR, OP_PROT, OP_ARRAY});
   assign lim = byte_mode ? 8'(DEPTH - 1) : 8'(DEPTH / 2 - 1);

   p_busy_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_oe != 16'hFFFF) |-> (rd_oe == 16'h0080 && rd_data[7] == 1'b0));

   p_busy_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (run_q < BUSY_CYC));

   p_busy_ignore_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && wr_stb) |=> ($stable(mode_q) && state_q == S_IDLE));

   p_count_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && wr_stb && state_q == S_BUF_CNT && wr_data[7:0] > lim)
      |=> (seq_err_q && state_q == S_IDLE));

   p_bad_confirm_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && wr_stb && state_q == S_BUF_CONF && wr_data[7:0] != OP_CONFIRM)
      |=> (seq_err_q && !busy));

   p_clear_locks_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && wr_stb && state_q == S_CLR_CONF && wr_data[7:0] == OP_CONFIRM)
      |=> (lock_vec == '0));

   p_locked_pgm_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && wr_stb && state_q == S_PGM_DATA && lock_vec[wr_addr[ARR_AW-1:BLK_AW]])
      |=> (lock_err_q && !busy));

   p_undef_code_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && wr_stb && state_q == S_IDLE && undef_code)
      |=> ($stable(mode_q) && state_q == S_IDLE));
endmodule

bind fcmd_seq fcmd_seq_chk #(
   .ARR_AW(ARR_AW), .BLK_AW(BLK_AW), .BUF_AW(BUF_AW), .BUSY_CYC(BUSY_CYC)
) chk_i (
   .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
   .byte_mode(byte_mode), .rd_data(rd_data), .rd_oe(rd_oe), .state_q(state_q),
   .mode_q(mode_q), .busy(busy), .seq_err_q(seq_err_q), .lock_err_q(lock_err_q),
   .lock_vec(lock_vec));

// File: tb/fcmd_seq_tb_top.sv
module fcmd_seq_tb_top;
   localparam int BUSY = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_stb = 1'b0;
   logic [5:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic        byte_mode = 1'b0;
   logic [6:0]  rd_addr = '0;
   logic [15:0] rd_data, rd_oe;

   int total = 0, fails = 0;
   bit done = 0;
   logic [15:0] m_arr [64];
   logic [15:0] m_prot [4];
   logic m_seq = 0, m_lk = 0;

   always #5 clk = ~clk;

   fcmd_seq #(.BUSY_CYC(BUSY)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
      .byte_mode(byte_mode), .rd_addr(rd_addr), .rd_data(rd_data), .rd_oe(rd_oe));

   function automatic logic [15:0] exp_status();
      return {8'h00, 1'b1, 1'b0, m_seq, m_lk, 4'h0};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [15:0] d);
      @(negedge clk); wr_stb = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk); wr_stb = 1'b0;
   endtask

   task automatic rd(input logic [6:0] a, output logic [31:0] v);
      @(negedge clk); rd_addr = a; #1; v = {rd_oe, rd_data};
   endtask

   task automatic wait_ready(input string req, output int n);
      n = 0;
      while (rd_oe == 16'h0080 && n < 1000) begin
         if (n == 0) chk({req, " busy mask R3"}, {rd_oe, 8'h00, rd_data[7], 7'h00}, {16'h0080, 16'h0000});
         n++;
         @(negedge clk);
      end
   endtask

   task automatic chk_status(input string req);
      logic [31:0] v;
      rd(7'h00, v);
      chk(req, v, {16'hFFFF, exp_status()});
   endtask

   task automatic chk_word(input string req, input logic [6:0] a);
      logic [31:0] v;
      rd(a, v);
      chk(req, v, {16'hFFFF, a[6] ? m_prot[a[1:0]] : m_arr[a[5:0]]});
   endtask

   task automatic do_buf(input logic [1:0] blk, input logic [4:0] n, input bit bm, input string req);
      logic [15:0] snap [64];
      logic [3:0]  offs [32];
      logic [15:0] dats [32];
      int c;
      byte_mode = bm;
      for (int i = 0; i < 64; i++) snap[i] = m_arr[i];
      wr(6'h00, 16'h00E8); m_seq = 0; m_lk = 0;
      wr({blk, 4'h0}, {8'h00, 3'b000, n});
      for (int i = 0; i <= int'(n); i++) begin
         offs[i] = 4'($urandom);
         dats[i] = 16'($urandom);
         wr({blk, offs[i]}, dats[i]);
      end
      wr(6'h00, 16'h00D0);
      for (int i = 0; i <= int'(n); i++) m_arr[{blk, offs[i]}] = snap[{blk, offs[i]}] & dats[i];
      wait_ready(req, c);
      chk({req, " busy length R4"}, c, BUSY);
      byte_mode = 1'b0;
      wr(6'h00, 16'h00FF);
      for (int i = 0; i < 16; i++) chk_word({req, " commit R5"}, {1'b0, blk, 4'(i)});
   endtask

   initial begin
      logic [31:0] v;
      int c;
      void'($urandom(32'd2718));
      for (int i = 0; i < 64; i++) m_arr[i] = 16'hFFFF;
      for (int i = 0; i < 4; i++) m_prot[i] = 16'hFFFF;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk_word("R1 array reset", 7'h00);
      chk_word("R1 array reset top", 7'h3F);
      chk_word("R1 protection reset", 7'h43);

      // R12 undefined code ignored, still array mode
      wr(6'h00, 16'h0077);
      chk_word("R12 undefined code", 7'h05);

      // R10 program into locked block 1 (R2 setup 0x40)
      wr(6'h00, 16'h0040);
      wr(6'h10, 16'h0000);
      m_lk = 1;
      rd(7'h10, v);
      chk("R10 lock error status", v, {16'hFFFF, exp_status()});
      wr(6'h00, 16'h00FF);
      chk_word("R10 locked word unchanged", 7'h10);

      // R9 / R13 clear locks, errors cleared by setup
      wr(6'h00, 16'h0060); m_lk = 0;
      wr(6'h00, 16'h00D0);
      wait_ready("R9", c);
      chk("R4 busy length clear", c, BUSY);
      chk_status("R13 status after clear");

      // R2 / R12 setup 0x10 with junk high byte
      wr(6'h00, 16'hAB10);
      wr(6'h10, 16'h1234); m_arr[16] = 16'h1234;
      wr(6'h00, 16'h00FF);   // R4 ignored while busy
      wait_ready("R2", c);
      chk_status("R4 write during busy ignored");
      wr(6'h00, 16'h00FF);
      chk_word("R2 program 0x10", 7'h10);
      wr(6'h00, 16'h0040);
      wr(6'h10, 16'hFF0F); m_arr[16] = 16'h1204;
      wait_ready("R2", c);
      chk("R4 busy length program", c, BUSY);
      wr(6'h00, 16'h00FF);
      chk_word("R2 AND merge", 7'h10);

      // R6 count too large in word mode
      wr(6'h00, 16'h00E8);
      wr(6'h00, 16'h0010); m_seq = 1;
      chk_status("R6 word count limit");

      // R7 wrong confirm
      wr(6'h00, 16'h00E8); m_seq = 0;
      wr(6'h00, 16'h0001);
      chk_status("R13 mid-sequence status");
      wr(6'h01, 16'h0000);
      wr(6'h02, 16'h0000);
      wr(6'h00, 16'h0055); m_seq = 1;
      chk_status("R7 abort status");
      wr(6'h00, 16'h00FF);
      chk_word("R7 array unchanged", 7'h01);

      // R8 address outside block
      wr(6'h00, 16'h00E8); m_seq = 0;
      wr(6'h20, 16'h0002);
      wr(6'h21, 16'h0000);
      wr(6'h05, 16'h0000); m_seq = 1;
      chk_status("R8 outside block");
      wr(6'h00, 16'h00FF);
      chk_word("R8 array unchanged", 7'h21);

      // R9 negative: bad second code
      wr(6'h00, 16'h0060); m_seq = 0;
      wr(6'h00, 16'h0033); m_seq = 1;
      chk_status("R9 bad clear confirm");

      // R11 protection program
      wr(6'h00, 16'h00C0); m_seq = 0;
      wr(6'h02, 16'h5A5A); m_prot[2] = 16'h5A5A;
      wait_ready("R11", c);
      chk("R4 busy length prot", c, BUSY);
      wr(6'h00, 16'h00FF);
      chk_word("R11 protection word", 7'h42);
      chk_word("R11 other protection word", 7'h40);

      // R5 / R6 byte mode maximal count
      do_buf(2'd2, 5'h1F, 1'b1, "R6 byte mode N=1F");
      do_buf(2'd3, 5'h0F, 1'b0, "R5 word mode N=0F");

      // Random mix
      for (int it = 0; it < 40; it++) begin
         if ($urandom % 2 == 0) begin
            logic [5:0]  a = 6'($urandom);
            logic [15:0] d = 16'($urandom);
            logic [7:0]  hi = 8'($urandom);
            wr(6'h00, {hi, ($urandom % 2 == 0) ? 8'h40 : 8'h10});
            wr(a, d); m_arr[a] = m_arr[a] & d;
            wait_ready("R2", c);
            chk("R4 busy length random", c, BUSY);
            wr(6'h00, 16'h00FF);
            chk_word("R2 random program", {1'b0, a});
         end else begin
            do_buf(2'($urandom), 5'($urandom % 16), 1'b0, "R5 random buffer");
         end
      end

      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++; fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end
endmodule